// File: doc/BRIEF.md
# LFSR Jump-Ahead Engine

This block takes a state of an XNOR-feedback linear feedback shift register and a skip count, and returns the state the register would hold after that many clock steps. It does not walk through the intermediate states. After reset it builds a table of affine transforms, one for each power-of-two distance. It starts from the single-step transform and squares it repeatedly. An apply operation then composes only the table rows that match the set bits of the skip count.

XNOR feedback makes the step function affine. Each row is therefore stored as a constant, which is the image of the all-zero state, plus one contribution vector per state bit. The work per jump grows with the width times the skip-count width, not with the length of the sequence. This keeps wide registers practical.

To move backwards by n steps, the caller requests a forward skip of (period − n). The caller starts an operation with a one-cycle `start` while `ready` is high. One clock is spent per skip-count bit, and `done` then marks the result.

Top module: `lfsr_jump`

## Requirements
- R1: After reset `ready` is low while the table is built. It rises within (SKW−1)·(W+1)+2 clock cycles and stays high until an operation is accepted.
- R2: One LFSR step is defined as next = {s[W−2:0], fb}, where fb is the inverted XOR of the bits of s selected by TAPS. A skip of 1 returns exactly this next state.
- R3: With W=5 and TAPS=5'b10010, a skip of 4 maps these states as follows: 0x00→0x0C, 0x01→0x19, 0x02→0x07, 0x04→0x0E, 0x08→0x09 and 0x10→0x06.
- R4: For any state and skip count k, `result` equals the state reached by applying the step of R2 k times.
- R5: A skip count of zero returns the input state unchanged.
- R6: On a maximal-length register (period 2^W−1), a forward skip of (period−n) undoes a forward skip of n.
- R7: The all-ones state, which the XNOR step maps to itself, is returned unchanged for any skip count.
- R8: The operation timing is fixed. `done` goes high exactly SKW clock edges after the edge that accepts `start`, and stays high for one cycle. `ready` is low from the accepting edge until `done` rises.
- R9: A `start` asserted while `ready` is low is ignored. The running operation's result is not altered, and no extra `done` pulse follows.
- R10: `result` holds its value from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a jump; accepted when `ready` is high |
| state_in | input | W | State the jump starts from |
| skip | input | SKW | Number of steps to advance |
| ready | output | 1 | Table built and engine idle |
| result | output | W | Jumped state; valid when `done` is high |
| done | output | 1 | One-cycle pulse marking a finished jump |

## Verification
The bench builds the block with W=5, TAPS=5'b10010 and SKW=5. In this configuration the period is 31, so every skip count the port can carry can also be reproduced by stepping a reference register in the bench. Row 2 of the table can be compared against the known four-step images, and backward jumps can be checked as forward jumps of 31−n. The same setting also exercises the all-ones lock state and the full five-row build sequence.

// File: rtl/lfsr_jump_pkg.sv
package lfsr_jump_pkg;
  typedef enum logic [1:0] {
    BLD_RUN  = 2'd0,
    BLD_DONE = 2'd1
  } bld_state_e;
endpackage

// File: rtl/lfsr_jump_affine.sv
module lfsr_jump_affine #(
  parameter int W = 5
) (
  input  logic [W-1:0]        cst,
  input  logic [W-1:0][W-1:0] cols,
  input  logic [W-1:0]        vin,
  output logic [W-1:0]        vout
);
  always_comb begin
    vout = cst;
    for (int i = 0; i < W; i++) begin
      if (vin[i]) vout = vout ^ cols[i];
    end
  end
endmodule

// File: rtl/lfsr_jump_table.sv
module lfsr_jump_table
  import lfsr_jump_pkg::*;
#(
  parameter int          W    = 5,
  parameter logic [W-1:0] TAPS = 5'b10010,
  parameter int          SKW  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(SKW)-1:0]    rd_idx,
  output logic [W-1:0]              rd_cst,
  output logic [W-1:0][W-1:0]       rd_cols,
  output logic                      built
);
  localparam int KW  = $clog2(SKW);
  localparam int BVW = $clog2(W + 1);

  function automatic logic [W-1:0] step_f(input logic [W-1:0] s);
    return {s[W-2:0], ~(^(s & TAPS))};
  endfunction

  logic [W-1:0]        cst_q  [SKW];
  logic [W-1:0][W-1:0] cols_q [SKW];

  bld_state_e     st_q, st_n;
  logic [KW-1:0]  row_q, row_n;
  logic [BVW-1:0] vec_q, vec_n;
  logic [BVW-1:0] vec_m1;
  logic [W-1:0]   basis, img1, img2, wr_val;
  logic           wr_en;
  logic [KW-1:0]  src_row;

  assign src_row = row_q - KW'(1);
  assign vec_m1  = vec_q - BVW'(1);
  assign basis   = (vec_q == '0) ? '0 : ({{(W-1){1'b0}}, 1'b1} << vec_m1);

  lfsr_jump_affine #(.W(W)) u_first (
    .cst(cst_q[src_row]), .cols(cols_q[src_row]), .vin(basis), .vout(img1)
  );
  lfsr_jump_affine #(.W(W)) u_second (
    .cst(cst_q[src_row]), .cols(cols_q[src_row]), .vin(img1), .vout(img2)
  );

  always_comb begin
    st_n   = st_q;
    row_n  = row_q;
    vec_n  = vec_q;
    wr_en  = 1'b0;
    wr_val = (vec_q == '0) ? img2 : (img2 ^ cst_q[row_q]);
    if (st_q == BLD_RUN) begin
      wr_en = 1'b1;
      if (vec_q == BVW'(W)) begin
        vec_n = '0;
        if (row_q == KW'(SKW - 1)) st_n = BLD_DONE;
        else                       row_n = row_q + KW'(1);
      end else begin
        vec_n = vec_q + BVW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BLD_RUN;
      row_q <= KW'(1);
      vec_q <= '0;
      for (int r = 0; r < SKW; r++) begin
        cst_q[r]  <= (r == 0) ? step_f('0) : '0;
        for (int i = 0; i < W; i++) begin
          cols_q[r][i] <= (r == 0) ? (step_f(W'(1) << i) ^ step_f('0)) : '0;
        end
      end
    end else begin
      st_q  <= st_n;
      row_q <= row_n;
      vec_q <= vec_n;
      if (wr_en) begin
        if (vec_q == '0) cst_q[row_q]          <= wr_val;
        else             cols_q[row_q][vec_m1] <= wr_val;
      end
    end
  end

  assign rd_cst  = cst_q[rd_idx];
  assign rd_cols = cols_q[rd_idx];
  assign built   = (st_q == BLD_DONE);
endmodule

// File: rtl/lfsr_jump.sv
module lfsr_jump #(
  parameter int          W    = 5,
  parameter logic [W-1:0] TAPS = 5'b10010,
  parameter int          SKW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   state_in,
  input  logic [SKW-1:0] skip,
  output logic           ready,
  output logic [W-1:0]   result,
  output logic           done
);
  localparam int KW = $clog2(SKW);

  logic                built;
  logic [W-1:0]        row_cst;
  logic [W-1:0][W-1:0] row_cols;
  logic [W-1:0]        jumped;

  logic           busy_q, busy_n;
  logic           done_q, done_n;
  logic [KW-1:0]  k_q, k_n;
  logic [W-1:0]   st_q, st_n;
  logic [SKW-1:0] sk_q, sk_n;

  lfsr_jump_table #(.W(W), .TAPS(TAPS), .SKW(SKW)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_idx(k_q),
    .rd_cst(row_cst), .rd_cols(row_cols), .built(built)
  );

  lfsr_jump_affine #(.W(W)) u_apply (
    .cst(row_cst), .cols(row_cols), .vin(st_q), .vout(jumped)
  );

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    k_n    = k_q;
    st_n   = st_q;
    sk_n   = sk_q;
    if (!busy_q) begin
      if (start && built) begin
        busy_n = 1'b1;
        k_n    = '0;
        st_n   = state_in;
        sk_n   = skip;
      end
    end else begin
      if (sk_q[k_q]) st_n = jumped;
      if (k_q == KW'(SKW - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        k_n = k_q + KW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      k_q    <= '0;
      st_q   <= '0;
      sk_q   <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      k_q    <= k_n;
      st_q   <= st_n;
      sk_q   <= sk_n;
    end
  end

  assign ready  = built && !busy_q;
  assign result = st_q;
  assign done   = done_q;
endmodule

// File: rtl/lfsr_jump_chk.sv
module lfsr_jump_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ready,
  input logic         done,
  input logic [W-1:0] result
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(ready));

  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);

  a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> $stable(result));

  a_r9_no_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> !done || $past(done, 1) == 1'b0);
endmodule

bind lfsr_jump lfsr_jump_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .ready(ready), .done(done), .result(result)
);

// File: tb/lfsr_jump_tb_top.sv
module lfsr_jump_tb_top;
  localparam int          W    = 5;
  localparam logic [W-1:0] TAPS = 5'b10010;
  localparam int          SKW  = 5;
  localparam int          PER  = 31;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   state_in = '0;
  logic [SKW-1:0] skip = '0;
  logic           ready, done;
  logic [W-1:0]   result;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lfsr_jump #(.W(W), .TAPS(TAPS), .SKW(SKW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .state_in(state_in),
    .skip(skip), .ready(ready), .result(result), .done(done)
  );

  function automatic logic [W-1:0] ref_jump(input logic [W-1:0] s, input int n);
    logic [W-1:0] v = s;
    for (int i = 0; i < n; i++) v = {v[W-2:0], ~(^(v & TAPS))};
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic jump(input logic [W-1:0] s, input int n, output logic [W-1:0] res,
                      output int lat);
    while (!ready) @(negedge clk);
    state_in = s; skip = SKW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    res = result;
  endtask

  task automatic t_reset();
    int cnt = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready low while building", ready, 0);
    while (!ready && cnt < 200) begin @(negedge clk); cnt++; end
    check("R1 ready within build bound", (cnt <= (SKW-1)*(W+1)+2), 1);
    repeat (3) @(negedge clk);
    check("R1 ready stays high", ready, 1);
  endtask

  task automatic t_single();
    logic [W-1:0] r; int lat;
    for (int s = 0; s < 32; s += 7) begin
      jump(W'(s), 1, r, lat);
      check("R2 one step", r, ref_jump(W'(s), 1));
    end
  endtask

  task automatic t_row2();
    logic [W-1:0] r; int lat;
    logic [W-1:0] ins [6] = '{5'h00, 5'h01, 5'h02, 5'h04, 5'h08, 5'h10};
    logic [W-1:0] exs [6] = '{5'h0C, 5'h19, 5'h07, 5'h0E, 5'h09, 5'h06};
    for (int i = 0; i < 6; i++) begin
      jump(ins[i], 4, r, lat);
      check("R3 four-step image", r, exs[i]);
    end
  endtask

  task automatic t_random();
    logic [W-1:0] r, s; int lat, n;
    for (int i = 0; i < 30; i++) begin
      s = W'($urandom);
      n = $urandom_range(0, (1 << SKW) - 1);
      jump(s, n, r, lat);
      check("R4 random jump", r, ref_jump(s, n));
      check("R8 latency", lat, SKW);
      @(negedge clk);
      check("R8 done one cycle", done, 0);
    end
  endtask

  task automatic t_zero();
    logic [W-1:0] r; int lat;
    jump(5'h0B, 0, r, lat);
    check("R5 zero skip", r, 5'h0B);
  endtask

  task automatic t_back();
    logic [W-1:0] a, b; int lat;
    jump(5'h05, 10, a, lat);
    jump(a, PER - 10, b, lat);
    check("R6 back by ten", b, 5'h05);
    jump(5'h16, PER - 3, a, lat);
    check("R6 back by three", a, ref_jump(5'h16, PER - 3));
    check("R6 forward three inverse", ref_jump(a, 3), 5'h16);
  endtask

  task automatic t_lock();
    logic [W-1:0] r; int lat;
    jump(5'h1F, 13, r, lat);
    check("R7 lock state", r, 5'h1F);
    jump(5'h1F, 31, r, lat);
    check("R7 lock state full", r, 5'h1F);
  endtask

  task automatic t_ignore();
    int lat = 0; int dones = 0;
    logic [W-1:0] keep;
    while (!ready) @(negedge clk);
    state_in = 5'h03; skip = SKW'(9); start = 1'b1;
    @(negedge clk);
    state_in = 5'h1A; skip = SKW'(2);
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    check("R9 running op kept", result, ref_jump(5'h03, 9));
    keep = result;
    for (int i = 0; i < SKW + 3; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check("R9 no extra done", dones, 0);
    check("R10 result held", result, keep);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_row2();
    t_random();
    t_zero();
    t_back();
    t_lock();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule